// File: doc/BRIEF.md
# Configurable RAM and ROM Bank Decoder

This block decodes a 64 KB processor address space in which every device is memory mapped. A three-bit size code chooses one of five RAM layouts. For each access the block raises at most one processor chip select, among three RAM banks, a paged system ROM and a one-page stack RAM, and it computes the address local to that device. All decoding is combinational. The read byte is multiplexed back to the processor, and any address that no device claims reads as 0xFF.

The two upper RAM banks form a byte-interleaved pair, with even bytes in one bank and odd bytes in the other. A display engine can therefore fetch both with one word address and get a 16-bit word back. The ROM area has a fixed lower part and an upper 4 KB window that shows one of several pages. A small register sets the page, and the processor writes it through a single control address.

Top module: `mem_bank_decoder`

## Requirements
- R1: The size code is captured on every clock edge while rst_n is low and held after reset. Codes: 0 = 8K, 1 = 12K, 2 = 32K, 3 = 36K, 4 = 48K, 5..7 = no RAM at all. Changing cfg_code after reset has no effect on decoding.
- R2: The low bank (a_cs) covers 0000 up to, but not including, a limit: 1000 for codes 1 and 3, 4000 for code 4, and nothing for the other codes. Its local address is cpu_addr[13:0].
- R3: The interleaved pair covers [lo, hi): code 0 is [0000, 2000), code 1 is [1000, 3000), code 2 is [0000, 8000), code 3 is [1000, 9000) and code 4 is [4000, C000). An even cpu_addr selects the even bank (b_cs). An odd cpu_addr selects the odd bank (c_cs). Both banks get the local address (cpu_addr - lo) >> 1.
- R4: While disp_req is high, b_cs and c_cs are both high and b_addr = c_addr = disp_addr. disp_data is {c_rdata, b_rdata}. A processor access to the pair in that cycle raises no select and reads 0xFF.
- R5: Addresses C000..DFFF select the ROM (rom_cs) with rom_addr = cpu_addr - C000.
- R6: Addresses E000..EFFF select the ROM with rom_addr = 2000 + page*1000 + cpu_addr[11:0].
- R7: A processor write (cpu_we high) to FF00 loads the page register from cpu_wdata[1:0] at the clock edge. Reset clears the page to 0. A write to any other address leaves the page unchanged.
- R8: Addresses F800..F8FF select the stack RAM (stk_cs) with stk_addr = cpu_addr[7:0].
- R9: An address that no device claims, including FF00 itself, raises no processor chip select and reads 0xFF on cpu_rdata.
- R10: At most one processor chip select is high at a time. cpu_rdata carries the read data of the selected device. mem_we equals cpu_we while a RAM or stack select is active, and is 0 for the ROM and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_code | input | 3 | RAM size code, captured during reset |
| cpu_addr | input | 16 | Processor byte address |
| cpu_we | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data returned to the processor |
| mem_we | output | 1 | Write enable to the selected RAM device |
| a_cs | output | 1 | Low bank select |
| a_addr | output | 14 | Low bank local address |
| a_rdata | input | 8 | Low bank read data |
| b_cs | output | 1 | Even bank select |
| b_addr | output | 14 | Even bank local address |
| b_rdata | input | 8 | Even bank read data |
| c_cs | output | 1 | Odd bank select |
| c_addr | output | 14 | Odd bank local address |
| c_rdata | input | 8 | Odd bank read data |
| rom_cs | output | 1 | ROM select |
| rom_addr | output | 15 | Linear ROM address |
| rom_rdata | input | 8 | ROM read data |
| stk_cs | output | 1 | Stack RAM select |
| stk_addr | output | 8 | Stack RAM local address |
| stk_rdata | input | 8 | Stack RAM read data |
| disp_req | input | 1 | Display fetch request |
| disp_addr | input | 14 | Display word address |
| disp_data | output | 16 | Display word, odd bank on the high byte |

## Verification
The bench sweeps all eight size codes. Under each code it sends random addresses drawn mostly from the region edges, so that any off-by-one in a window limit appears as the wrong select or the wrong local address. Even and odd addresses inside the pair separate the two banks and expose a wrong halving of the offset. Random page writes, followed by reads of the paged window, separate page arithmetic from the fixed ROM part. Display cycles run alongside a processor access to the pair to show the display has priority, and a change of cfg_code after reset shows the captured code is the one in use.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

   // RAM window for one size code; the upper limits are exclusive
   typedef struct packed {
      logic [16:0] a_lim;
      logic [16:0] bc_lo;
      logic [16:0] bc_hi;
   } ram_win_t;

   function automatic ram_win_t win_of(input logic [2:0] code);
      ram_win_t w;
      case (code)
         3'd0:    w = '{a_lim: 17'h00000, bc_lo: 17'h00000, bc_hi: 17'h02000};
         3'd1:    w = '{a_lim: 17'h01000, bc_lo: 17'h01000, bc_hi: 17'h03000};
         3'd2:    w = '{a_lim: 17'h00000, bc_lo: 17'h00000, bc_hi: 17'h08000};
         3'd3:    w = '{a_lim: 17'h01000, bc_lo: 17'h01000, bc_hi: 17'h09000};
         3'd4:    w = '{a_lim: 17'h04000, bc_lo: 17'h04000, bc_hi: 17'h0C000};
         default: w = '{a_lim: 17'h00000, bc_lo: 17'h00000, bc_hi: 17'h00000};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/mbd_ctl.sv
module mbd_ctl #(
   parameter int          BSW         = 2,
   parameter logic [15:0] ROMSEL_ADDR = 16'hFF00
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     cfg_code,
   input  logic [15:0]    cpu_addr,
   input  logic           cpu_we,
   input  logic [BSW-1:0] wr_page,
   output logic [2:0]     cfg_q,
   output logic [BSW-1:0] page_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= cfg_code;
         page_q <= '0;
      end else if (cpu_we && cpu_addr == ROMSEL_ADDR) begin
         page_q <= wr_page;
      end
   end

   a_r1_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(cfg_q));

   a_r7_page_reset: assert property (@(posedge clk)
      !rst_n |=> page_q == '0);

   a_r7_page_other: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_we || cpu_addr != ROMSEL_ADDR) |=> $stable(page_q));

endmodule

// File: rtl/mbd_ram_map.sv
module mbd_ram_map
   import mbd_pkg::*;
#(
   parameter int DW       = 8,
   parameter int BANK_AW  = 14,
   parameter bit ODD_TO_C = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  ram_win_t           win,
   input  logic [15:0]        cpu_addr,
   input  logic               disp_req,
   input  logic [BANK_AW-1:0] disp_addr,
   input  logic [DW-1:0]      b_rdata,
   input  logic [DW-1:0]      c_rdata,
   output logic               a_cs,
   output logic [BANK_AW-1:0] a_addr,
   output logic               b_cs,
   output logic [BANK_AW-1:0] b_addr,
   output logic               c_cs,
   output logic [BANK_AW-1:0] c_addr,
   output logic               cpu_b,
   output logic               cpu_c,
   output logic [2*DW-1:0]    disp_data
);

   localparam int XW = 17;

   logic [XW-1:0]      addr_x;
   logic [XW-1:0]      pair_off;
   logic               in_pair;
   logic               odd_side;
   logic [BANK_AW-1:0] pair_loc;
   logic               unused_off;

   assign addr_x     = {1'b0, cpu_addr};
   assign in_pair    = (addr_x >= win.bc_lo) && (addr_x < win.bc_hi);
   assign pair_off   = addr_x - win.bc_lo;
   assign pair_loc   = pair_off[BANK_AW:1];
   assign unused_off = ^{pair_off[XW-1:BANK_AW+1], pair_off[0]};

   assign a_cs   = addr_x < win.a_lim;
   assign a_addr = cpu_addr[BANK_AW-1:0];

   generate
      if (ODD_TO_C) begin : g_odd_c
         assign odd_side  = cpu_addr[0];
         assign disp_data = {c_rdata, b_rdata};
      end else begin : g_odd_b
         assign odd_side  = ~cpu_addr[0];
         assign disp_data = {b_rdata, c_rdata};
      end
   endgenerate

   assign cpu_b  = in_pair && !disp_req && !odd_side;
   assign cpu_c  = in_pair && !disp_req &&  odd_side;
   assign b_cs   = disp_req || cpu_b;
   assign c_cs   = disp_req || cpu_c;
   assign b_addr = disp_req ? disp_addr : pair_loc;
   assign c_addr = disp_req ? disp_addr : pair_loc;

   a_r4_disp_pair: assert property (@(posedge clk) disable iff (!rst_n)
      disp_req |-> (b_cs && c_cs && b_addr == c_addr && !cpu_b && !cpu_c));

   a_r2_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
      a_cs |-> cpu_addr < 16'h4000);

   a_r3_pair_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_b || cpu_c) |-> cpu_addr < 16'hC000);

endmodule

// File: rtl/mbd_rom_map.sv
module mbd_rom_map #(
   parameter int         ROM_BANKS = 4,
   parameter logic [7:0] STK_PAGE  = 8'hF8,
   localparam int        BSW       = $clog2(ROM_BANKS),
   localparam int        ROM_AW    = $clog2(8192 + ROM_BANKS * 4096)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [BSW-1:0]    page,
   output logic              rom_cs,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              stk_cs,
   output logic [7:0]        stk_addr
);

   localparam int FIX_SIZE = 8192;

   logic fix_hit;
   logic win_hit;

   assign fix_hit = cpu_addr[15:13] == 3'b110;
   assign win_hit = cpu_addr[15:12] == 4'hE;
   assign rom_cs  = fix_hit || win_hit;

   always_comb begin
      if (fix_hit)
         rom_addr = ROM_AW'(cpu_addr[12:0]);
      else
         rom_addr = ROM_AW'(FIX_SIZE) + ROM_AW'({page, 12'h000}) + ROM_AW'(cpu_addr[11:0]);
   end

   assign stk_cs   = cpu_addr[15:8] == STK_PAGE;
   assign stk_addr = cpu_addr[7:0];

   a_r6_window_above_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> rom_addr >= ROM_AW'(FIX_SIZE));

   a_r5_fixed_below: assert property (@(posedge clk) disable iff (!rst_n)
      fix_hit |-> rom_addr < ROM_AW'(FIX_SIZE));

endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
   import mbd_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 8,
   parameter int          BANK_AW     = 14,
   parameter int          ROM_BANKS   = 4,
   parameter logic [15:0] ROMSEL_ADDR = 16'hFF00,
   parameter logic [7:0]  STK_PAGE    = 8'hF8,
   localparam int         BSW         = $clog2(ROM_BANKS),
   localparam int         ROM_AW      = $clog2(8192 + ROM_BANKS * 4096)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         cfg_code,
   input  logic [AW-1:0]      cpu_addr,
   input  logic               cpu_we,
   input  logic [DW-1:0]      cpu_wdata,
   output logic [DW-1:0]      cpu_rdata,
   output logic               mem_we,
   output logic               a_cs,
   output logic [BANK_AW-1:0] a_addr,
   input  logic [DW-1:0]      a_rdata,
   output logic               b_cs,
   output logic [BANK_AW-1:0] b_addr,
   input  logic [DW-1:0]      b_rdata,
   output logic               c_cs,
   output logic [BANK_AW-1:0] c_addr,
   input  logic [DW-1:0]      c_rdata,
   output logic               rom_cs,
   output logic [ROM_AW-1:0]  rom_addr,
   input  logic [DW-1:0]      rom_rdata,
   output logic               stk_cs,
   output logic [7:0]         stk_addr,
   input  logic [DW-1:0]      stk_rdata,
   input  logic               disp_req,
   input  logic [BANK_AW-1:0] disp_addr,
   output logic [2*DW-1:0]    disp_data
);

   generate
      if (AW != 16) begin : g_bad_aw
         $error("mem_bank_decoder: AW must be 16");
      end
      if (BANK_AW != 14) begin : g_bad_bank
         $error("mem_bank_decoder: BANK_AW must be 14");
      end
      if (ROM_BANKS < 2 || ROM_BANKS > 4) begin : g_bad_rom
         $error("mem_bank_decoder: ROM_BANKS must be 2..4");
      end
      if (DW < BSW) begin : g_bad_dw
         $error("mem_bank_decoder: DW too narrow for page field");
      end
   endgenerate

   logic [2:0]     cfg_q;
   logic [BSW-1:0] page_q;
   ram_win_t       win;
   logic           cpu_b;
   logic           cpu_c;
   logic           ram_hit;
   logic           unused_wdata;

   assign unused_wdata = ^cpu_wdata[DW-1:BSW];

   mbd_ctl #(.BSW(BSW), .ROMSEL_ADDR(ROMSEL_ADDR)) ctl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_code (cfg_code),
      .cpu_addr (cpu_addr),
      .cpu_we   (cpu_we),
      .wr_page  (cpu_wdata[BSW-1:0]),
      .cfg_q    (cfg_q),
      .page_q   (page_q)
   );

   assign win = win_of(cfg_q);

   mbd_ram_map #(.DW(DW), .BANK_AW(BANK_AW), .ODD_TO_C(1'b1)) ram_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .win       (win),
      .cpu_addr  (cpu_addr),
      .disp_req  (disp_req),
      .disp_addr (disp_addr),
      .b_rdata   (b_rdata),
      .c_rdata   (c_rdata),
      .a_cs      (a_cs),
      .a_addr    (a_addr),
      .b_cs      (b_cs),
      .b_addr    (b_addr),
      .c_cs      (c_cs),
      .c_addr    (c_addr),
      .cpu_b     (cpu_b),
      .cpu_c     (cpu_c),
      .disp_data (disp_data)
   );

   mbd_rom_map #(.ROM_BANKS(ROM_BANKS), .STK_PAGE(STK_PAGE)) rom_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_addr (cpu_addr),
      .page     (page_q),
      .rom_cs   (rom_cs),
      .rom_addr (rom_addr),
      .stk_cs   (stk_cs),
      .stk_addr (stk_addr)
   );

   assign ram_hit = a_cs || cpu_b || cpu_c || stk_cs;
   assign mem_we  = cpu_we && ram_hit;

   always_comb begin
      if (a_cs)        cpu_rdata = a_rdata;
      else if (cpu_b)  cpu_rdata = b_rdata;
      else if (cpu_c)  cpu_rdata = c_rdata;
      else if (rom_cs) cpu_rdata = rom_rdata;
      else if (stk_cs) cpu_rdata = stk_rdata;
      else             cpu_rdata = '1;
   end

   a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_cs, cpu_b, cpu_c, rom_cs, stk_cs}));

   a_r9_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_cs || cpu_b || cpu_c || rom_cs || stk_cs) |-> cpu_rdata == '1);

   a_r10_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_cs || !cpu_we) |-> !mem_we);

endmodule

// File: tb/mem_bank_decoder_tb.sv
module mem_bank_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  cfg_code;
   logic [15:0] cpu_addr;
   logic        cpu_we;
   logic [7:0]  cpu_wdata;
   logic [7:0]  cpu_rdata;
   logic        mem_we;
   logic        a_cs, b_cs, c_cs, rom_cs, stk_cs;
   logic [13:0] a_addr, b_addr, c_addr;
   logic [14:0] rom_addr;
   logic [7:0]  stk_addr;
   logic [7:0]  a_rdata, b_rdata, c_rdata, rom_rdata, stk_rdata;
   logic        disp_req;
   logic [13:0] disp_addr;
   logic [15:0] disp_data;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   // device models: data is a fixed pattern of the local address
   function automatic logic [7:0] pat_a(input logic [13:0] x);   return x[7:0] ^ 8'h11; endfunction
   function automatic logic [7:0] pat_b(input logic [13:0] x);   return x[7:0] ^ 8'h22 ^ {2'b00, x[13:8]}; endfunction
   function automatic logic [7:0] pat_c(input logic [13:0] x);   return x[7:0] ^ 8'h33 ^ {x[13:8], 2'b00}; endfunction
   function automatic logic [7:0] pat_rom(input logic [14:0] x); return x[7:0] ^ {1'b0, x[14:8]} ^ 8'h5C; endfunction
   function automatic logic [7:0] pat_stk(input logic [7:0] x);  return x ^ 8'h44; endfunction

   assign a_rdata   = pat_a(a_addr);
   assign b_rdata   = pat_b(b_addr);
   assign c_rdata   = pat_c(c_addr);
   assign rom_rdata = pat_rom(rom_addr);
   assign stk_rdata = pat_stk(stk_addr);

   mem_bank_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code),
      .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .mem_we(mem_we),
      .a_cs(a_cs), .a_addr(a_addr), .a_rdata(a_rdata),
      .b_cs(b_cs), .b_addr(b_addr), .b_rdata(b_rdata),
      .c_cs(c_cs), .c_addr(c_addr), .c_rdata(c_rdata),
      .rom_cs(rom_cs), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
      .stk_cs(stk_cs), .stk_addr(stk_addr), .stk_rdata(stk_rdata),
      .disp_req(disp_req), .disp_addr(disp_addr), .disp_data(disp_data)
   );

   // expected device: 0 none, 1 low bank, 2 even bank, 3 odd bank, 4 ROM, 5 stack
   function automatic void model(input int ad, input int cf, input int pg,
                                 output int sel, output int loc);
      int alim, lo, hi;
      case (cf)
         0: begin alim = 0;       lo = 0;       hi = 'h2000; end
         1: begin alim = 'h1000;  lo = 'h1000;  hi = 'h3000; end
         2: begin alim = 0;       lo = 0;       hi = 'h8000; end
         3: begin alim = 'h1000;  lo = 'h1000;  hi = 'h9000; end
         4: begin alim = 'h4000;  lo = 'h4000;  hi = 'hC000; end
         default: begin alim = 0; lo = 0;       hi = 0;      end
      endcase
      sel = 0; loc = 0;
      if (ad < alim) begin sel = 1; loc = ad; end
      else if (ad >= lo && ad < hi) begin sel = (ad % 2 == 1) ? 3 : 2; loc = (ad - lo) / 2; end
      else if (ad >= 'hC000 && ad < 'hE000) begin sel = 4; loc = ad - 'hC000; end
      else if (ad >= 'hE000 && ad < 'hF000) begin sel = 4; loc = 'h2000 + pg * 'h1000 + (ad % 'h1000); end
      else if (ad >= 'hF800 && ad < 'hF900) begin sel = 5; loc = ad - 'hF800; end
   endfunction

   function automatic logic [7:0] exp_data(input int sel, input int loc);
      case (sel)
         1: return pat_a(14'(loc));
         2: return pat_b(14'(loc));
         3: return pat_c(14'(loc));
         4: return pat_rom(15'(loc));
         5: return pat_stk(8'(loc));
         default: return 8'hFF;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // drive one processor access, compare before the next rising edge
   task automatic access(input int ad, input bit we, input logic [7:0] wd,
                         input int cf, input int pg, input string req);
      int sel, loc, act_sel, act_loc;
      bit exp_we;
      @(negedge clk);
      cpu_addr = 16'(ad); cpu_we = we; cpu_wdata = wd; disp_req = 1'b0;
      #1;
      model(ad, cf, pg, sel, loc);
      act_sel = {a_cs, b_cs, c_cs, rom_cs, stk_cs} == 5'b10000 ? 1 :
                {a_cs, b_cs, c_cs, rom_cs, stk_cs} == 5'b01000 ? 2 :
                {a_cs, b_cs, c_cs, rom_cs, stk_cs} == 5'b00100 ? 3 :
                {a_cs, b_cs, c_cs, rom_cs, stk_cs} == 5'b00010 ? 4 :
                {a_cs, b_cs, c_cs, rom_cs, stk_cs} == 5'b00001 ? 5 :
                {a_cs, b_cs, c_cs, rom_cs, stk_cs} == 5'b00000 ? 0 : 9;
      case (act_sel)
         1: act_loc = int'(a_addr);
         2: act_loc = int'(b_addr);
         3: act_loc = int'(c_addr);
         4: act_loc = int'(rom_addr);
         5: act_loc = int'(stk_addr);
         default: act_loc = 0;
      endcase
      exp_we = we && (sel == 1 || sel == 2 || sel == 3 || sel == 5);
      check(act_sel == sel, {req, " R10 select"}, act_sel, sel);
      check(act_loc == loc, {req, " local addr"}, act_loc, loc);
      check(cpu_rdata == exp_data(sel, loc), {req, " R10 rdata"}, int'(cpu_rdata), int'(exp_data(sel, loc)));
      check(mem_we == exp_we, {req, " R10 mem_we"}, int'(mem_we), int'(exp_we));
   endtask

   task automatic do_reset(input int cf);
      @(negedge clk);
      rst_n = 1'b0; cfg_code = 3'(cf); cpu_we = 1'b0; disp_req = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic int pick_addr(input int cf);
      int r, edges[12];
      edges = '{0, 'h0FFF, 'h1000, 'h1FFF, 'h2000, 'h2FFF, 'h3FFF, 'h7FFF,
                'h8FFF, 'hBFFF, 'hDFFF, 'hF7FF};
      r = int'($urandom_range(0, 9));
      if (r < 4) return int'($urandom_range(0, 'hFFFF));
      if (r < 8) return edges[$urandom_range(0, 11)] + int'($urandom_range(0, 2)) - 1 & 'hFFFF;
      if (r == 8) return 'hE000 + int'($urandom_range(0, 'hFFF));
      return 'hF7FE + int'($urandom_range(0, 'h104));
   endfunction

   initial begin
      int pg;
      void'($urandom(32'h1D5E_0A17));
      rst_n = 1'b0; cfg_code = 3'd4; cpu_addr = '0; cpu_we = 1'b0;
      cpu_wdata = '0; disp_req = 1'b0; disp_addr = '0;

      for (int cf = 0; cf < 8; cf++) begin
         do_reset(cf);
         pg = 0;
         // reset state: page 0 visible in the paged window
         access('hE123, 0, 8'h00, cf, 0, "R7 reset page");
         access('hC000, 0, 8'h00, cf, 0, "R5 fixed base");
         access('hDFFF, 0, 8'h00, cf, 0, "R5 fixed top");
         access('hF800, 0, 8'h00, cf, 0, "R8 stack base");
         access('hF8FF, 0, 8'h00, cf, 0, "R8 stack top");
         access('hF900, 0, 8'h00, cf, 0, "R9 above stack");
         access('hFF00, 0, 8'h00, cf, 0, "R9 control addr read");
         for (int i = 0; i < 350; i++) begin
            int ad;
            bit we;
            logic [7:0] wd;
            wd = 8'($urandom);
            if ($urandom_range(0, 15) == 0) begin
               access('hFF00, 1, wd, cf, pg, "R7 page write");
               pg = int'(wd[1:0]);
               access('hE000 + int'($urandom_range(0, 'hFFF)), 0, 8'h00, cf, pg, "R6 paged read");
            end else begin
               ad = pick_addr(cf);
               we = 1'($urandom);
               access(ad, we, wd, cf, pg, "R2 R3 R5 R6 R8 R9 random");
               if (ad == 'hFF00 && we) pg = int'(wd[1:0]);
            end
         end
         // a write elsewhere leaves the page alone
         access('hFF01, 1, 8'h03 ^ 8'(pg), cf, pg, "R7 near-miss write");
         access('hEFFF, 0, 8'h00, cf, pg, "R7 page kept");
      end

      // R1: capture during reset only
      do_reset(4);
      @(negedge clk); cfg_code = 3'd0;
      access('h3000, 0, 8'h00, 4, 0, "R1 code held");
      access('hBFFF, 0, 8'h00, 4, 0, "R1 pair top held");
      do_reset(1);
      @(negedge clk); cfg_code = 3'd7;
      access('h0FFF, 0, 8'h00, 1, 0, "R1 low bank held");
      access('h1001, 0, 8'h00, 1, 0, "R1 odd bank held");

      // R4: display priority over the pair
      do_reset(3);
      for (int i = 0; i < 40; i++) begin
         logic [13:0] da;
         int ad;
         logic [15:0] expw;
         da = 14'($urandom);
         ad = 'h1000 + int'($urandom_range(0, 'h7FFF));
         @(negedge clk);
         disp_req = 1'b1; disp_addr = da; cpu_addr = 16'(ad); cpu_we = 1'b1;
         #1;
         expw = {pat_c(da), pat_b(da)};
         check(b_cs && c_cs, "R4 both selects", int'({b_cs, c_cs}), 3);
         check(b_addr == da && c_addr == da, "R4 word address", int'(b_addr), int'(da));
         check(disp_data == expw, "R4 display word", int'(disp_data), int'(expw));
         check(cpu_rdata == 8'hFF, "R4 cpu blocked rdata", int'(cpu_rdata), 'hFF);
         check(mem_we == 1'b0, "R4 cpu blocked write", int'(mem_we), 0);
      end
      @(negedge clk); disp_req = 1'b0; cpu_we = 1'b0;
      access('h1001, 0, 8'h00, 3, 0, "R3 after display");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_500_000;
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule